// File: doc/BRIEF.md
# NAND Hamming ECC Accumulator

This block watches the byte stream that a NAND flash controller moves to and from the flash bus. It builds a single-error-correcting Hamming code over every 256-byte chunk. The code is 16 bits of line parity and 6 bits of column parity, packed into three code bytes. It keeps one code per chunk for `NUM_CHUNKS` chunks, so with the default of two chunks a 512-byte page yields six code bytes.

A 2-bit mode input drives the block. Software first selects clear, then off, then accumulate, and then moves the page. Each completed byte strobe folds one byte into the code of the current chunk. Software then selects readout and pulls the stored code bytes through the data port, one per read strobe. Correcting the data is left to software, which compares the stored code with the calculated one.

Top module: `nand_ecc_accum`

## Requirements
- R1: `mode` is decoded as 2'b00 off, 2'b01 accumulate, 2'b10 readout and 2'b11 clear. In off mode every stored code and the byte index hold their values.
- R2: One clock edge in clear mode, or a synchronous `rst`, zeroes every chunk's parity state and the byte index. A following readout then returns 8'hFF for every code byte.
- R3: A byte is folded in only on a clock edge where `mode` is accumulate and `byte_valid` is 1. Strobes in off or readout mode change no stored code and do not move the byte index.
- R4: Column parity bit 2j+1 (j = 0..2) is the XOR of all data bits whose bit position has bit j set. Bit 2j is the XOR of those whose position has bit j clear. Code byte 2 is {~cp[5:0], 2'b11}.
- R5: Line parity bit 2k+1 (k = 0..7) is the XOR of the parities of the bytes whose offset in the chunk has bit k set. Bit 2k covers the bytes with bit k clear. Code byte 0 is ~lp[7:0] and code byte 1 is ~lp[15:8].
- R6: After every 256th accepted byte the following bytes go to the next chunk's code. The index wraps to chunk 0 after the last chunk.
- R7: Readout returns, per chunk in ascending chunk order, code byte 1, then code byte 0, then code byte 2. Each `rd_strobe` edge in readout mode steps to the next byte. After the last byte of the last chunk it wraps to the first.
- R8: In the first cycle of readout mode the output shows code byte 1 of chunk 0, whatever was read before.
- R9: Outside readout mode `ecc_byte` is 8'h00.
- R10: Accumulation paused by off mode resumes at the same byte index. The result equals that of an uninterrupted transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operating mode (off, accumulate, readout, clear) |
| byte_valid | input | 1 | A data byte transfer completed in this cycle |
| byte_data | input | 8 | Data byte on the flash bus |
| rd_strobe | input | 1 | Data-port read of one code byte in readout mode |
| ecc_byte | output | 8 | Current code byte in readout mode, zero otherwise |

## Verification
The bench builds the block with its default of two chunks. A full 512-byte page therefore exercises the move to the second chunk's code, and the readout pointer crosses from chunk 0 into chunk 1 and wraps back. The page patterns are chosen so that both chunks differ, which exposes a swapped chunk select or order. A paused transfer and stray strobes in the off and readout modes show that the byte index holds.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int CHUNK_ADDR_W = 8;
    localparam int CHUNK_BYTES  = 1 << CHUNK_ADDR_W;
    localparam int LINE_W       = 2 * CHUNK_ADDR_W;
    localparam int COL_W        = 6;
    localparam int CODE_BYTES   = 3;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_ACC  = 2'b01,
        MODE_READ = 2'b10,
        MODE_CLR  = 2'b11
    } ecc_mode_e;

    typedef struct packed {
        logic [LINE_W-1:0] lp;
        logic [COL_W-1:0]  cp;
    } chunk_code_t;

    // column parity contribution of one data byte
    function automatic logic [COL_W-1:0] col_parity(input logic [7:0] d);
        logic [COL_W-1:0] c;
        c[0] = ^(d & 8'h55);
        c[1] = ^(d & 8'hAA);
        c[2] = ^(d & 8'h33);
        c[3] = ^(d & 8'hCC);
        c[4] = ^(d & 8'h0F);
        c[5] = ^(d & 8'hF0);
        return c;
    endfunction

    // which stored code byte a readout slot presents: 1, 0, 2
    function automatic logic [1:0] slot_to_byte(input logic [1:0] slot);
        case (slot)
            2'd0:    return 2'd1;
            2'd1:    return 2'd0;
            default: return 2'd2;
        endcase
    endfunction

    // inverted code byte as presented on the data port
    function automatic logic [7:0] code_byte(input chunk_code_t c, input logic [1:0] sel);
        case (sel)
            2'd0:    return ~c.lp[7:0];
            2'd1:    return ~c.lp[15:8];
            default: return {~c.cp, 2'b11};
        endcase
    endfunction

endpackage

// File: rtl/ecc_chunk_acc.sv
module ecc_chunk_acc
    import nand_ecc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    en,
    input  logic [CHUNK_ADDR_W-1:0] addr,
    input  logic [7:0]              data,
    output chunk_code_t             code
);

    chunk_code_t code_q;
    logic [LINE_W-1:0] lp_next;
    logic              byte_par;

    always_comb begin
        byte_par = ^data;
        lp_next  = code_q.lp;
        for (int k = 0; k < CHUNK_ADDR_W; k++) begin
            if (addr[k]) lp_next[2*k+1] = lp_next[2*k+1] ^ byte_par;
            else         lp_next[2*k]   = lp_next[2*k]   ^ byte_par;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            code_q <= '0;
        end else if (en) begin
            code_q.lp <= lp_next;
            code_q.cp <= code_q.cp ^ col_parity(data);
        end
    end

    assign code = code_q;

    // R2
    acc_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (code == '0));

    // R3
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !en) |=> $stable(code));

endmodule

// File: rtl/ecc_readout.sv
module ecc_readout
    import nand_ecc_pkg::*;
#(
    parameter int NUM_CHUNKS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        active,
    input  logic        rd_strobe,
    input  chunk_code_t codes [NUM_CHUNKS],
    output logic [7:0]  ecc_byte
);

    localparam int CH_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CHUNKS - 1);

    logic            was_active;
    logic            entering;
    logic [1:0]      slot_q, slot_eff;
    logic [CH_W-1:0] chunk_q, chunk_eff;

    assign entering  = active && !was_active;
    assign slot_eff  = entering ? 2'd0 : slot_q;
    assign chunk_eff = entering ? '0 : chunk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            was_active <= 1'b0;
            slot_q     <= '0;
            chunk_q    <= '0;
        end else begin
            was_active <= active;
            if (active && rd_strobe) begin
                if (slot_eff == 2'(CODE_BYTES - 1)) begin
                    slot_q  <= '0;
                    chunk_q <= (chunk_eff == LAST_CH) ? '0 : chunk_eff + CH_W'(1);
                end else begin
                    slot_q  <= slot_eff + 2'd1;
                    chunk_q <= chunk_eff;
                end
            end else if (entering) begin
                slot_q  <= '0;
                chunk_q <= '0;
            end
        end
    end

    always_comb begin
        ecc_byte = 8'h00;
        if (active) ecc_byte = code_byte(codes[chunk_eff], slot_to_byte(slot_eff));
    end

    // R8
    rd_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !was_active && !rd_strobe) |=> (slot_q == 2'd0 && chunk_q == '0));

    // R7
    rd_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && was_active && rd_strobe && slot_q == 2'd0)
        |=> (slot_q == 2'd1 && chunk_q == $past(chunk_q)));

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
    import nand_ecc_pkg::*;
#(
    parameter int NUM_CHUNKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       rd_strobe,
    output logic [7:0] ecc_byte
);

    localparam int TOTAL_BYTES = NUM_CHUNKS * CHUNK_BYTES;
    localparam int CNT_W       = $clog2(TOTAL_BYTES);
    localparam int CH_W        = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TOTAL_BYTES - 1);

    ecc_mode_e   mode_e;
    logic        accept, clear, reading;
    logic [CNT_W-1:0]        cnt_q;
    logic [CHUNK_ADDR_W-1:0] byte_addr;
    logic [CH_W-1:0]         chunk_idx;
    chunk_code_t             codes [NUM_CHUNKS];

    assign mode_e    = ecc_mode_e'(mode);
    assign accept    = (mode_e == MODE_ACC) && byte_valid;
    assign clear     = (mode_e == MODE_CLR);
    assign reading   = (mode_e == MODE_READ);
    assign byte_addr = cnt_q[CHUNK_ADDR_W-1:0];
    assign chunk_idx = CH_W'(cnt_q >> CHUNK_ADDR_W);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    generate
        for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_chunk
            ecc_chunk_acc u_acc (
                .clk  (clk),
                .rst  (rst),
                .clr  (clear),
                .en   (accept && (chunk_idx == CH_W'(g))),
                .addr (byte_addr),
                .data (byte_data),
                .code (codes[g])
            );
        end
    endgenerate

    ecc_readout #(.NUM_CHUNKS(NUM_CHUNKS)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .active    (reading),
        .rd_strobe (rd_strobe),
        .codes     (codes),
        .ecc_byte  (ecc_byte)
    );

    // R2
    cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && cnt_q != LAST_IDX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!accept && !clear) |=> $stable(cnt_q));

    // R9
    out_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b10) |-> (ecc_byte == 8'h00));

endmodule

// File: tb/nand_ecc_accum_tb.sv
module nand_ecc_accum_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 2;
    localparam int NVEC       = 6;
    // {seed, step}: byte i of page = seed ^ (i*step) ^ (i >= 256 ? 8'h3C : 0)
    localparam logic [15:0] VEC [NVEC] = '{16'h0000, 16'hFF00, 16'h0001,
                                           16'h5A37, 16'hA50D, 16'h0180};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       rd_strobe = 1'b0;
    logic [7:0] ecc_byte;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_ecc_accum #(.NUM_CHUNKS(NCH)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .rd_strobe  (rd_strobe),
        .ecc_byte   (ecc_byte)
    );

    function automatic logic [7:0] pat(input int e, input int i);
        logic [7:0] s, st;
        s  = VEC[e][15:8];
        st = VEC[e][7:0];
        return s ^ 8'(i * st) ^ ((i >= 256) ? 8'h3C : 8'h00);
    endfunction

    // returns {byte2, byte1, byte0} built bit by bit from R4/R5
    function automatic logic [23:0] ref_code(input int e, input int c);
        logic [15:0] lp = '0;
        logic [5:0]  cp = '0;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] d;
            d = pat(e, c*256 + i);
            for (int b = 0; b < 8; b++) begin
                if (d[b]) begin
                    for (int j = 0; j < 3; j++) cp[2*j + ((b >> j) & 1)] ^= 1'b1;
                    for (int k = 0; k < 8; k++) lp[2*k + ((i >> k) & 1)] ^= 1'b1;
                end
            end
        end
        return {~cp, 2'b11, ~lp[15:8], ~lp[7:0]};
    endfunction

    // k-th byte of readout sequence (R7): per chunk byte1, byte0, byte2
    function automatic logic [7:0] exp_read(input int e, input int k);
        logic [23:0] c;
        c = ref_code(e, k / 3);
        case (k % 3)
            0:       return c[15:8];
            1:       return c[7:0];
            default: return c[23:16];
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode = m;
    endtask

    task automatic send(input int e, input int from, input int to);
        for (int i = from; i < to; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_data  = pat(e, i);
        end
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic junk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_data  = 8'(8'hC3 + i * 29);
        end
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk);
        #1;
        v = ecc_byte;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic start_page();
        set_mode(2'b11);
        set_mode(2'b00);
        set_mode(2'b01);
    endtask

    task automatic read_page(input string req, input int e);
        logic [7:0] v;
        set_mode(2'b00);
        set_mode(2'b10);
        for (int k = 0; k < 3*NCH; k++) begin
            rd(v);
            chk(req, v, exp_read(e, k));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 reset idle output", ecc_byte, 8'h00);

        // R2: after hardware reset all codes read as FF
        set_mode(2'b10);
        for (int k = 0; k < 3*NCH; k++) begin
            rd(v);
            chk("R2 reset code", v, 8'hFF);
        end

        // table walk: R4 R5 R6 R7 over several page patterns
        for (int e = 0; e < NVEC; e++) begin
            start_page();
            send(e, 0, 512);
            read_page("R4 R5 R6 R7 page code", e);
        end

        // R2: clear mode wipes a loaded page
        start_page();
        send(3, 0, 512);
        set_mode(2'b11);
        set_mode(2'b00);
        set_mode(2'b10);
        for (int k = 0; k < 3*NCH; k++) begin
            rd(v);
            chk("R2 clear mode", v, 8'hFF);
        end

        // R10 + R3 + R1: paused transfer with stray strobes in off mode
        start_page();
        send(4, 0, 100);
        set_mode(2'b00);
        junk(7);
        set_mode(2'b01);
        send(4, 100, 300);
        set_mode(2'b00);
        junk(3);
        set_mode(2'b01);
        send(4, 300, 512);
        read_page("R10 R1 paused accumulation", 4);

        // R3: strobes during readout are ignored, R8 re-entry restarts
        set_mode(2'b10);
        junk(9);
        set_mode(2'b00);
        #1;
        chk("R9 off output", ecc_byte, 8'h00);
        read_page("R3 readout-mode strobes ignored", 4);

        // R8: partial read, leave and re-enter readout
        set_mode(2'b00);
        set_mode(2'b10);
        rd(v);
        rd(v);
        set_mode(2'b00);
        set_mode(2'b10);
        #1;
        chk("R8 re-entry first byte", ecc_byte, exp_read(4, 0));

        // R7: wrap after last byte
        for (int k = 0; k < 3*NCH; k++) rd(v);
        rd(v);
        chk("R7 wrap to first", v, exp_read(4, 0));

        // R9: accumulate mode output idle
        set_mode(2'b01);
        #1;
        chk("R9 accumulate output", ecc_byte, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule